// File: doc/BRIEF.md
# Modular Additive Stream Scrambler

This block turns a stream of 17-bit message words into 18-bit scrambled words, one word per clock. Two coupled 18-bit accumulators, called X and Y here, advance on every accepted word. Y is driven only by itself and X. X absorbs the message together with Y. Each accumulator keeps a one-bit carry that feeds into its next addition. Every sum is folded back below the modulus 258114 (2^18 − 4030) with an end-around correction.

The correction is built as a double adder. The plain sum and the sum plus 4030 are formed side by side, and a single bit picks the one to keep. This leaves one carry chain on the path that decides the cycle time. The seeds are parameters, and a synchronous init puts them back into the registers. The scrambled word is the freshly updated X. A valid flag marks it, and this flag follows the input strobe by one clock.

Top module: `mod_stream_scrambler`

## Requirements
- R1: While `init` is high at a rising edge, X is loaded with SEED_X (default 187319), Y with SEED_Y (default 111981), both carries are cleared and `out_valid` goes low; `out_word` then shows SEED_X.
- R2: For an accepted word, the X sum is the message zero-extended to 18 bits, plus the old Y, plus the old X carry.
- R3: For an accepted word, the Y sum is the old X plus the old Y plus the old Y carry, where X and Y are the values from before this update.
- R4: A sum s is folded as follows. The carry is bit 18 of (s OR (s+4030)). When the carry is set, the register takes bits 17..0 of s+4030, otherwise bits 17..0 of s. The new carry is stored for the next word. So a sum of 258113 stays 258113 with carry 0, 258114 gives 0, 262143 gives 4029 and 262144 gives 4030, each of the last three with carry 1.
- R5: One clock after a rising edge with `in_valid` high, `out_valid` is 1 and `out_word` holds the newly updated X.
- R6: A rising edge with `in_valid` low changes neither accumulator nor carry. The next clock has `out_valid` at 0 and `out_word` unchanged, and the stream later continues as if the idle cycle had not occurred.
- R7: From the default seeds, the message 1234 yields 113215, and the following message 38650 yields 79836.
- R8: Both accumulators always stay below 258114.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| init | input | 1 | Synchronous seed load, active high |
| in_valid | input | 1 | Accept `msg_in` and advance the state this cycle |
| msg_in | input | 17 | Message word |
| out_valid | output | 1 | `out_word` carries a freshly scrambled word |
| out_word | output | 18 | Scrambled word (current X) |

## Verification
The hardest case to reach is an X sum that lands exactly on a fold boundary (258113, 258114, 262143, 262144). It depends on the hidden Y value and the hidden carry, and neither shows at the ports. The bench runs its own model of both accumulators. It feeds random words until the model's Y is large enough that a legal 17-bit message can close the gap to the target. It then sends that exact message and checks the folded result against the value R4 predicts. Idle gaps and a re-init in the middle of the stream are mixed into a long random run, so the model has to keep lockstep with the design across every kind of cycle.

// File: rtl/mscr_pkg.sv
package mscr_pkg;

  localparam int unsigned WORD_W = 18;

  typedef struct packed {
    logic              carry;
    logic [WORD_W-1:0] value;
  } fold_t;

  // Double adder: plain and corrected sums are formed independently,
  // then the carry picks one of them.
  function automatic fold_t fold_sum(input logic [WORD_W-1:0] a,
                                     input logic [WORD_W-1:0] b,
                                     input logic              cin,
                                     input logic [WORD_W-1:0] adj);
    logic [WORD_W+1:0] plain;
    logic [WORD_W+1:0] shifted;
    fold_t             r;
    plain   = {2'b00, a} + {2'b00, b} + {{(WORD_W+1){1'b0}}, cin};
    shifted = {2'b00, a} + {2'b00, b} + {2'b00, adj} + {{(WORD_W+1){1'b0}}, cin};
    r.carry = plain[WORD_W] | shifted[WORD_W];
    r.value = r.carry ? shifted[WORD_W-1:0] : plain[WORD_W-1:0];
    return r;
  endfunction

endpackage

// File: rtl/mscr_lane.sv
module mscr_lane
  import mscr_pkg::*;
#(
  parameter logic [WORD_W-1:0] SEED = '0,
  parameter logic [WORD_W-1:0] ADJ  = 18'd4030
) (
  input  logic              clk,
  input  logic              init,
  input  logic              en,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] val_q,
  output logic              carry_q
);

  localparam logic [WORD_W:0] MODV = {1'b1, {WORD_W{1'b0}}} - {1'b0, ADJ};

  fold_t           nxt;
  logic [WORD_W:0] raw_sum;

  assign nxt     = fold_sum(op_a, op_b, carry_q, ADJ);
  assign raw_sum = {1'b0, op_a} + {1'b0, op_b} + {{WORD_W{1'b0}}, carry_q};

  always_ff @(posedge clk) begin
    if (init) begin
      val_q   <= SEED;
      carry_q <= 1'b0;
    end else if (en) begin
      val_q   <= nxt.value;
      carry_q <= nxt.carry;
    end
  end

  // R4: the stored value plus the modulus when the carry is set restores the raw sum
  a_r4_fold_residue: assert property (@(posedge clk) disable iff (init)
    en |=> (({1'b0, val_q} + (carry_q ? MODV : '0)) == $past(raw_sum)));

  // R6: no update without enable
  a_r6_lane_hold: assert property (@(posedge clk) disable iff (init)
    !en |=> ($stable(val_q) && $stable(carry_q)));

  // R8: accumulator stays below the modulus
  a_r8_below_modulus: assert property (@(posedge clk) disable iff (init)
    ({1'b0, val_q} < MODV));

endmodule

// File: rtl/mod_stream_scrambler.sv
module mod_stream_scrambler
  import mscr_pkg::*;
#(
  parameter int unsigned       MSG_W  = 17,
  parameter logic [WORD_W-1:0] SEED_X = 18'd187319,
  parameter logic [WORD_W-1:0] SEED_Y = 18'd111981,
  parameter logic [WORD_W-1:0] ADJ    = 18'd4030
) (
  input  logic              clk,
  input  logic              init,
  input  logic              in_valid,
  input  logic [MSG_W-1:0]  msg_in,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);

  localparam int unsigned     PAD_W = WORD_W - MSG_W;
  localparam logic [WORD_W:0] MODV  = {1'b1, {WORD_W{1'b0}}} - {1'b0, ADJ};

  logic [WORD_W-1:0] msg_ext;
  logic [WORD_W-1:0] x_val, y_val;
  logic              x_cy, y_cy;

  assign msg_ext = {{PAD_W{1'b0}}, msg_in};

  // X path: message + Y + X carry
  mscr_lane #(.SEED(SEED_X), .ADJ(ADJ)) u_xlane (
    .clk(clk), .init(init), .en(in_valid),
    .op_a(msg_ext), .op_b(y_val),
    .val_q(x_val), .carry_q(x_cy)
  );

  // Y path: X + Y + Y carry
  mscr_lane #(.SEED(SEED_Y), .ADJ(ADJ)) u_ylane (
    .clk(clk), .init(init), .en(in_valid),
    .op_a(x_val), .op_b(y_val),
    .val_q(y_val), .carry_q(y_cy)
  );

  always_ff @(posedge clk) begin
    if (init) out_valid <= 1'b0;
    else      out_valid <= in_valid;
  end

  assign out_word = x_val;

  // R2: X takes message + old Y + old X carry, modulo the fold
  a_r2_x_source: assert property (@(posedge clk) disable iff (init)
    in_valid |=> (({1'b0, out_word} + (x_cy ? MODV : '0)) ==
                  $past({1'b0, msg_ext} + {1'b0, y_val} + {{WORD_W{1'b0}}, x_cy})));

  // R3: Y takes old X + old Y + old Y carry
  a_r3_y_source: assert property (@(posedge clk) disable iff (init)
    in_valid |=> (({1'b0, y_val} + (y_cy ? MODV : '0)) ==
                  $past({1'b0, x_val} + {1'b0, y_val} + {{WORD_W{1'b0}}, y_cy})));

  // R5: valid follows an accepted word
  a_r5_valid_follows: assert property (@(posedge clk) disable iff (init)
    in_valid |=> out_valid);

  // R6: idle cycle leaves output word and drops valid
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (init)
    !in_valid |=> (!out_valid && $stable(out_word)));

endmodule

// File: tb/sim_mod_stream_scrambler.sv
module sim_mod_stream_scrambler;

  logic        clk = 1'b0;
  logic        init = 1'b1;
  logic        in_valid = 1'b0;
  logic [16:0] msg_in = '0;
  logic        out_valid;
  logic [17:0] out_word;

  int total = 0;
  int bad = 0;
  int mx, my, mcx, mcy;

  mod_stream_scrambler u0 (
    .clk(clk), .init(init), .in_valid(in_valid),
    .msg_in(msg_in), .out_valid(out_valid), .out_word(out_word)
  );

  always #10 clk = ~clk;

  // behavioural fold: reduce by the modulus when adding 4030 reaches 2^18
  function automatic bit fold_c(int s);
    return (s + 4030) >= 262144;
  endfunction
  function automatic int fold_v(int s);
    return fold_c(s) ? s - 258114 : s;
  endfunction

  task automatic check(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_seed();
    mx = 187319; my = 111981; mcx = 0; mcy = 0;
  endtask

  // called at a negedge; returns at the next negedge
  task automatic push(int m, bit v, string tag);
    int sx, sy;
    msg_in = 17'(m);
    in_valid = v;
    @(posedge clk);
    if (v) begin
      sx = m + my + mcx;
      sy = mx + my + mcy;
      mx = fold_v(sx); mcx = int'(fold_c(sx));
      my = fold_v(sy); mcy = int'(fold_c(sy));
    end
    @(negedge clk);
    check({tag, " R5/R6 valid"}, int'(out_valid), int'(v));
    check({tag, " R2/R3 word"}, int'(out_word), mx);
  endtask

  task automatic do_init();
    init = 1'b1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    init = 1'b0;
    model_seed();
    check("R1 valid after init", int'(out_valid), 0);
    check("R1 seed on output", int'(out_word), 187319);
  endtask

  // steer the X sum onto a chosen value, then check the folded result
  task automatic hit(int target, int expv, int expc);
    int m;
    int tries;
    tries = 0;
    m = target - my - mcx;
    while ((m < 0 || m > 131071) && tries < 3000) begin
      push(int'($urandom_range(131071)), 1'b1, "R4 approach");
      tries++;
      m = target - my - mcx;
    end
    if (m < 0 || m > 131071) begin
      check("R4 boundary not reached", 0, 1);
    end else begin
      push(m, 1'b1, "R4 boundary");
      check("R4 folded value", mx, expv);
      check("R4 folded carry", mcx, expc);
      check("R4 port value", int'(out_word), expv);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : stim
    @(negedge clk);
    do_init();

    // R7 known vectors
    push(1234, 1'b1, "R7 first");
    check("R7 first vector", int'(out_word), 113215);
    push(38650, 1'b1, "R7 second");
    check("R7 second vector", int'(out_word), 79836);

    // R6 idle gaps, state must resume unchanged
    push(99999, 1'b0, "R6 idle");
    push(5, 1'b0, "R6 idle");
    push(76066, 1'b1, "R6 resume");

    // R2/R3 random stream with random idles
    for (int i = 0; i < 400; i++) begin
      push(int'($urandom_range(131071)), ($urandom_range(3) != 0), "R2 stream");
      check("R8 below modulus", int'(out_word < 18'd258114), 1);
    end

    // extreme messages
    for (int i = 0; i < 20; i++) push(131071, 1'b1, "R2 all-ones");
    for (int i = 0; i < 20; i++) push(0, 1'b1, "R3 zero msg");

    // R4 boundaries around the modulus and 2^18
    hit(258113, 258113, 0);
    hit(258114, 0, 1);
    hit(262143, 4029, 1);
    hit(262144, 4030, 1);
    hit(258112, 258112, 0);

    // R1 re-init mid stream, then R7 again
    push(4242, 1'b1, "R1 pre");
    do_init();
    push(1234, 1'b1, "R1 reseed");
    check("R1 reseed vector", int'(out_word), 113215);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule